// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

This block is a 16-bit timer/counter made of two 8-bit count halves. A two-bit mode field arranges the halves in one of four ways: two independent prescaled timers, a prescaled timer beside an event counter, one chained 16-bit prescaled timer, or one chained 16-bit event counter. A shared programmable prescaler supplies the timer ticks. The event input and two capture strobes each pass through a two-flop synchronizer and a rising-edge detector.

Each half counts up to its match value, reloads to zero and raises a sticky interrupt flag. A rising edge on a capture strobe copies the live count into a capture register. Software drives the block through a small register port. It writes the mode, prescaler and match values, clears flags, and reads captures and live counts.

Top module: `capture_timer`

## Requirements
- R1: In timed arrangements a half advances once every (prescale + 1) clock cycles. The first advance comes on the (prescale + 1)-th rising edge after the edge that wrote the mode register.
- R2: In an 8-bit arrangement a half counts 0, 1, … up to its match value. On the next advance it reloads to 0 and, on that same edge, sets its flag (irq_lo for the low half, irq_hi for the high half).
- R3: Mode 0: both halves are prescaled timers, each with its own match value. The event input has no effect on either count.
- R4: Mode 1: the low half is a prescaled timer. The high half advances by one per synchronized rising edge of evt_in and ignores the prescaler.
- R5: Mode 2: the halves form one 16-bit prescaled timer, with carry from low to high. It reloads when the count equals {match_hi, match_lo}. That reload sets irq_hi only, and irq_lo never sets in modes 2 and 3.
- R6: Mode 3: the halves form one 16-bit counter of evt_in rising edges. It uses the same 16-bit match, reload and irq_hi behaviour as mode 2.
- R7: An evt_in high pulse lasting one clock cycle is counted once. An input held high for many cycles also counts only once.
- R8: A cap_lo_in rising edge loads capture-low with the low count. In modes 2 and 3 the same edge also loads capture-high with the high count. A cap_hi_in rising edge loads capture-high in modes 0 and 1 only; in modes 2 and 3 it has no effect.
- R9: Suppose a capture strobe is first sampled high at clock edge X. The captured value is then the count held just after edge X+1, and it is readable after edge X+2.
- R10: Writing address 0 restarts both counts and the prescaler at zero. It leaves the prescale value, the match values and the flags unchanged.
- R11: Flags are sticky. Writing address 6 clears irq_lo where data bit 0 is 1 and irq_hi where data bit 1 is 1.
- R12: Register port. Address 0 takes the mode on write bits [1:0] and reads as {0, irq_hi, irq_lo, mode[1:0]}. Address 1 holds the prescale value, address 2 match_lo and address 3 match_hi. Addresses 4 and 5 read capture-low and capture-high. Addresses 6 and 7 read the low and high counts. After reset the mode, prescale, counts, captures and flags are 0, and both match values are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| evt_in | input | 1 | Asynchronous event input |
| cap_lo_in | input | 1 | Asynchronous low/wide capture strobe |
| cap_hi_in | input | 1 | Asynchronous high-half capture strobe |
| irq_lo | output | 1 | Sticky low-half reload flag |
| irq_hi | output | 1 | Sticky high-half or 16-bit reload flag |

## Verification
A wrong prescaler or match state shows up within one count period as a live count that differs from floor(k/(P+1)) mod (M+1), read back cycle by cycle after a mode write. A broken carry or mode decode in the chained arrangements shows up at the 0x00FF to 0x0100 boundary and at the 16-bit reload, where the irq_hi edge must land on an exact cycle. Synchronizer or capture faults show as captured values that are off by one, or as counts that follow held or ignored inputs. These appear a few cycles after each strobe or event burst.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL     = 2'd0,
        MODE_SPLIT    = 2'd1,
        MODE_WIDE_TMR = 2'd2,
        MODE_WIDE_EVT = 2'd3
    } ct_mode_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_PRE    = 3'd1;
    localparam logic [2:0] A_MLO    = 3'd2;
    localparam logic [2:0] A_MHI    = 3'd3;
    localparam logic [2:0] A_CAPLO  = 3'd4;
    localparam logic [2:0] A_CAPHI  = 3'd5;
    localparam logic [2:0] A_CNTLO  = 3'd6;  // write: flag clear
    localparam logic [2:0] A_CNTHI  = 3'd7;

    function automatic logic is_wide(input ct_mode_e m);
        return (m == MODE_WIDE_TMR) || (m == MODE_WIDE_EVT);
    endfunction

    function automatic logic lo_on_events(input ct_mode_e m);
        return m == MODE_WIDE_EVT;
    endfunction

    function automatic logic hi_on_events(input ct_mode_e m);
        return (m == MODE_SPLIT) || (m == MODE_WIDE_EVT);
    endfunction

endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int SHW = STAGES + 1;

    logic [SHW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SHW-2:0], din};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ct_half.sv
module ct_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         step,
    input  logic         reload,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (step)      cnt <= reload ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ct_pkg::*;
#(
    parameter int W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         evt_in,
    input  logic         cap_lo_in,
    input  logic         cap_hi_in,
    output logic         irq_lo,
    output logic         irq_hi
);
    localparam int PADW = W - 4;

    ct_mode_e     mode_q;
    logic [W-1:0] pre_q, mlo_q, mhi_q, cap_lo_q, cap_hi_q;
    logic         flag_lo_q, flag_hi_q;
    logic [W-1:0] cnt_lo, cnt_hi;

    logic mode_wr, flag_wr, wide, tick;
    logic evt_rise, cap_lo_rise, cap_hi_rise;
    logic lo_step, hi_step, lo_reload, hi_reload, full_match;

    assign mode_wr = wr_en && (wr_addr == A_CTRL);
    assign flag_wr = wr_en && (wr_addr == A_CNTLO);
    assign wide    = is_wide(mode_q);

    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_evt (
        .clk(clk), .rst(rst), .din(evt_in), .rise(evt_rise));
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_caplo (
        .clk(clk), .rst(rst), .din(cap_lo_in), .rise(cap_lo_rise));
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_caphi (
        .clk(clk), .rst(rst), .din(cap_hi_in), .rise(cap_hi_rise));

    ct_prescaler #(.W(W)) u_pre (
        .clk(clk), .rst(rst), .restart(mode_wr), .limit(pre_q), .tick(tick));

    always_comb begin
        full_match = (cnt_lo == mlo_q) && (cnt_hi == mhi_q);
        lo_step    = lo_on_events(mode_q) ? evt_rise : tick;
        if (wide) begin
            lo_reload = full_match;
            hi_reload = full_match;
            hi_step   = lo_step && ((cnt_lo == '1) || full_match);
        end else begin
            lo_reload = (cnt_lo == mlo_q);
            hi_reload = (cnt_hi == mhi_q);
            hi_step   = hi_on_events(mode_q) ? evt_rise : tick;
        end
    end

    ct_half #(.W(W)) u_lo (
        .clk(clk), .rst(rst), .restart(mode_wr),
        .step(lo_step), .reload(lo_reload), .cnt(cnt_lo));
    ct_half #(.W(W)) u_hi (
        .clk(clk), .rst(rst), .restart(mode_wr),
        .step(hi_step), .reload(hi_reload), .cnt(cnt_hi));

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_DUAL;
            pre_q  <= '0;
            mlo_q  <= '1;
            mhi_q  <= '1;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  mode_q <= ct_mode_e'(wr_data[1:0]);
                A_PRE:   pre_q  <= wr_data;
                A_MLO:   mlo_q  <= wr_data;
                A_MHI:   mhi_q  <= wr_data;
                default: ;
            endcase
        end
    end

    // sticky flags: a set on the same edge wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_lo_q <= 1'b0;
            flag_hi_q <= 1'b0;
        end else begin
            if (!wide && lo_step && lo_reload) flag_lo_q <= 1'b1;
            else if (flag_wr && wr_data[0])    flag_lo_q <= 1'b0;
            if (hi_step && hi_reload)          flag_hi_q <= 1'b1;
            else if (flag_wr && wr_data[1])    flag_hi_q <= 1'b0;
        end
    end

    // capture registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_lo_q <= '0;
            cap_hi_q <= '0;
        end else begin
            if (cap_lo_rise) cap_lo_q <= cnt_lo;
            if (wide) begin
                if (cap_lo_rise) cap_hi_q <= cnt_hi;
            end else if (cap_hi_rise) begin
                cap_hi_q <= cnt_hi;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {{PADW{1'b0}}, flag_hi_q, flag_lo_q, mode_q};
            A_PRE:   rd_data = pre_q;
            A_MLO:   rd_data = mlo_q;
            A_MHI:   rd_data = mhi_q;
            A_CAPLO: rd_data = cap_lo_q;
            A_CAPHI: rd_data = cap_hi_q;
            A_CNTLO: rd_data = cnt_lo;
            default: rd_data = cnt_hi;
        endcase
    end

    assign irq_lo = flag_lo_q;
    assign irq_hi = flag_hi_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_wr,
    input logic         wide,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic [W-1:0] cap_lo_q,
    input logic [W-1:0] cap_hi_q,
    input logic         cap_lo_rise,
    input logic         irq_lo
);
    assert_mode_restart_R10: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (cnt_lo == '0 && cnt_hi == '0));

    assert_lo_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_lo != $past(cnt_lo)) |-> (cnt_lo == $past(cnt_lo) + 1'b1 || cnt_lo == '0));

    assert_flag_on_reload_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_lo) |-> (cnt_lo == '0));

    assert_no_lo_flag_wide_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_lo) |-> !$past(wide));

    assert_cap_lo_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_lo_q) |-> $past(cap_lo_rise));

    assert_cap_hi_ignored_wide_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(wide) && !$past(cap_lo_rise)) |-> $stable(cap_hi_q));
endmodule

bind capture_timer ct_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .wide(wide),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q),
    .cap_lo_rise(cap_lo_rise), .irq_lo(irq_lo));

// File: tb/capture_timer_bench.sv
module capture_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       evt_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
    logic       irq_lo, irq_hi;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    capture_timer u_capture_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in),
        .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in), .irq_lo(irq_lo), .irq_hi(irq_hi));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at that negedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic evt_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            evt_in = 1'b1;
            @(negedge clk);
            evt_in = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic strobe(input bit lo, input bit hi);
        cap_lo_in = lo; cap_hi_in = hi;
        @(negedge clk);
        cap_lo_in = 1'b0; cap_hi_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int v, v2, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(3'd0, v); chk("R12 ctrl reset", v, 0);
        rd(3'd2, v); chk("R12 match_lo reset", v, 255);
        rd(3'd3, v); chk("R12 match_hi reset", v, 255);
        rd(3'd6, v); chk("R12 count_lo reset", v, 0);
        chk("R12 irq reset", {irq_hi, irq_lo}, 0);

        // R1 R2 R3 sweep of prescale and match in mode 0
        for (int p = 0; p < 4; p++) begin
            for (int m = 2; m <= 5; m += 3) begin
                wr(3'd2, 8'(m));
                wr(3'd3, 8'(m + 1));
                wr(3'd1, 8'(p));
                wr(3'd6, 8'h03);
                wr(3'd0, 8'd0);
                for (int k = 1; k <= (m + 3) * (p + 1); k++) begin
                    @(negedge clk);
                    rd(3'd6, v);
                    chk("R1 R2 count_lo", v, (k / (p + 1)) % (m + 1));
                    rd(3'd7, v);
                    chk("R3 count_hi", v, (k / (p + 1)) % (m + 2));
                    chk("R2 irq_lo", irq_lo, (k >= (m + 1) * (p + 1)) ? 1 : 0);
                end
            end
        end

        // R11 flag clear, R12 readback
        rd(3'd0, v); chk("R12 ctrl flags", v, 12);
        wr(3'd6, 8'h01);
        chk("R11 irq_lo cleared", irq_lo, 0);
        chk("R11 irq_hi kept", irq_hi, 1);
        wr(3'd6, 8'h02);
        chk("R11 irq_hi cleared", irq_hi, 0);

        // R3 events ignored in mode 0
        wr(3'd1, 8'd255);
        wr(3'd2, 8'd255); wr(3'd3, 8'd255);
        wr(3'd0, 8'd0);
        evt_pulses(6);
        rd(3'd6, v); chk("R3 lo ignores events", v, 0);
        rd(3'd7, v); chk("R3 hi ignores events", v, 0);

        // R4 R7 mode 1
        wr(3'd0, 8'd1);
        evt_pulses(7);
        repeat (3) @(negedge clk);
        rd(3'd7, v); chk("R4 R7 hi event count", v, 7);
        rd(3'd6, v); chk("R4 lo still prescaled", v, 0);
        evt_in = 1'b1;
        repeat (12) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(3'd7, v); chk("R7 long high counted once", v, 8);

        // R9 capture timing in mode 0
        wr(3'd1, 8'd0);
        wr(3'd0, 8'd0);
        repeat (5) @(negedge clk);
        strobe(1'b1, 1'b1);
        rd(3'd4, v); chk("R9 cap_lo value", v, 7);
        rd(3'd5, v); chk("R8 R9 cap_hi value", v, 7);

        // R5 mode 2 16-bit timer
        wr(3'd2, 8'd5); wr(3'd3, 8'd1);
        wr(3'd6, 8'h03);
        wr(3'd0, 8'd2);
        for (int k = 1; k <= 264; k++) begin
            @(negedge clk);
            rd(3'd6, v); rd(3'd7, v2);
            e = k % 262;
            chk("R5 wide count", v2 * 256 + v, e);
            chk("R5 irq_hi", irq_hi, (k >= 262) ? 1 : 0);
            chk("R5 irq_lo stays low", irq_lo, 0);
        end

        // R10 mode write keeps config and flags
        wr(3'd0, 8'd2);
        rd(3'd6, v); chk("R10 count restarted", v, 0);
        rd(3'd2, v); chk("R10 match kept", v, 5);
        chk("R10 flag kept", irq_hi, 1);
        wr(3'd6, 8'h02);

        // R6 R8 mode 3 wide event counter and capture
        wr(3'd2, 8'd255); wr(3'd3, 8'd255);
        wr(3'd0, 8'd3);
        evt_pulses(300);
        repeat (3) @(negedge clk);
        rd(3'd6, v); rd(3'd7, v2);
        chk("R6 wide event count", v2 * 256 + v, 300);
        strobe(1'b1, 1'b0);
        rd(3'd4, v); rd(3'd5, v2);
        chk("R8 wide capture", v2 * 256 + v, 300);
        evt_pulses(5);
        strobe(1'b0, 1'b1);
        rd(3'd5, v); chk("R8 cap_hi strobe ignored wide", v, 1);
        rd(3'd4, v); chk("R8 cap_lo unchanged", v, 44);

        // R6 16-bit match in event mode
        wr(3'd2, 8'd3); wr(3'd3, 8'd0);
        wr(3'd0, 8'd3);
        evt_pulses(3);
        repeat (3) @(negedge clk);
        chk("R6 no flag before match", irq_hi, 0);
        evt_pulses(1);
        repeat (3) @(negedge clk);
        chk("R6 flag at wide reload", irq_hi, 1);
        rd(3'd6, v); chk("R6 count reloaded", v, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule